// File: doc/BRIEF.md
# Fine-Grain Round-Robin Fetch Thread Scheduler

This block chooses, on every clock, which of N hardware threads places its next instruction into a shared in-order pipeline. Each thread owns a program counter and a ready flag. The scheduler scans the ready threads in rotating order. It starts one position past the thread it granted last, so a different thread can fill each successive fetch slot. A switch between threads costs no cycles.

Cache misses come back from the pipeline as reports. Each report carries a thread number and the PC at which that thread must resume. An instruction-fetch miss names the missed instruction itself. A data miss names the instruction after the one that missed. The thread leaves the rotation in the cycle of the report, and the other threads keep the pipeline busy. The block raises a squash bit for that thread so the pipeline can discard its in-flight work. A per-thread wake pulse returns the thread to the rotation at the PC it saved.

Top module: `mtsch_fetch_sched`

## Requirements
- R1: After reset every thread is ready, thread t holds PC `BOOT_PC + t*BOOT_STEP`, and the first fetch goes to thread 0.
- R2: In any cycle where at least one thread is eligible (ready and not reported missing in that cycle), `fetch_vld_o` is 1. `fetch_tid_o` names the first eligible thread found by scanning upward from the rotation pointer and wrapping at N. The pointer then moves to the granted thread plus one, modulo N. No idle slot is inserted between threads.
- R3: `fetch_pc_o` equals the granted thread's current PC, and that thread's PC then advances by `INSTB`.
- R4: An instruction-miss report (`imiss_vld_i`, thread, PC) keeps that thread from being granted in the same cycle. It clears the thread's ready flag and loads the reported PC into the thread.
- R5: A data-miss report does the same with its own PC. For either kind of report, `squash_o[t]` is 1 in that cycle, where t is the reported thread, and every other squash bit is 0.
- R6: A thread whose ready flag is clear is never granted.
- R7: `wake_i[t]` sets thread t ready from the next cycle. The thread then resumes at its saved PC.
- R8: If a miss report and `wake_i` name the same thread in the same cycle, the miss wins and the thread stays not ready.
- R9: If both miss kinds name the same thread in one cycle, the thread resumes at the data-miss PC.
- R10: When no thread is eligible, `fetch_vld_o`, `fetch_tid_o` and `fetch_pc_o` are all 0 and the rotation pointer does not move.
- R11: A thread that stays eligible is granted after at most N-1 cycles without a grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| imiss_vld_i | input | 1 | Instruction-fetch miss report |
| imiss_tid_i | input | TW | Thread of the fetch miss |
| imiss_pc_i | input | PCW | PC of the missed instruction |
| dmiss_vld_i | input | 1 | Data miss report |
| dmiss_tid_i | input | TW | Thread of the data miss |
| dmiss_pc_i | input | PCW | PC of the instruction after the missing load |
| wake_i | input | N | Per-thread miss-completion pulse |
| fetch_vld_o | output | 1 | A fetch is issued this cycle |
| fetch_tid_o | output | TW | Thread that fetches |
| fetch_pc_o | output | PCW | PC to fetch |
| squash_o | output | N | Per-thread discard of in-flight work |

## Verification
The fetch outputs are decoded from registered state through one level of logic. A wrong ready flag, a wrong saved PC or a wrong rotation pointer therefore shows up at the ports on the next cycle in which that thread is due for a grant. That is at most N cycles later. A lost wake leaves a thread that never reappears in `fetch_tid_o`. A bad PC restore appears as an unexpected `fetch_pc_o` on the first grant after the wake. A pointer that moves during an idle cycle changes the order of the next grants.

// File: rtl/mtsch_pkg.sv
package mtsch_pkg;
   // selects how the rotating priority search is built
   typedef enum int {
      PICK_SCAN   = 0,
      PICK_DOUBLE = 1
   } pick_style_e;
endpackage

// File: rtl/mtsch_rr_pick.sv
module mtsch_rr_pick #(
   parameter int N     = 4,
   parameter int TW    = 2,
   parameter int STYLE = 0
) (
   input  logic [N-1:0]  req_i,
   input  logic [TW-1:0] ptr_i,
   output logic          any_o,
   output logic [TW-1:0] idx_o
);
   import mtsch_pkg::*;

   generate
      if (STYLE == PICK_SCAN) begin : g_scan
         // walk the offsets from the pointer, wrapping by subtraction
         always_comb begin
            any_o = 1'b0;
            idx_o = '0;
            for (int o = 0; o < N; o++) begin
               int k;
               k = int'(ptr_i) + o;
               if (k >= N) k = k - N;
               if (!any_o && req_i[k]) begin
                  any_o = 1'b1;
                  idx_o = TW'(k);
               end
            end
         end
      end else begin : g_double
         // doubled request vector, lower copy masked below the pointer
         logic [2*N-1:0] dbl;
         always_comb begin
            dbl   = {req_i, req_i};
            any_o = 1'b0;
            idx_o = '0;
            for (int j = 0; j < 2*N; j++) begin
               if (!any_o && dbl[j] && (j >= int'(ptr_i))) begin
                  any_o = 1'b1;
                  idx_o = (j >= N) ? TW'(j - N) : TW'(j);
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/mtsch_thr_ctx.sv
module mtsch_thr_ctx #(
   parameter int              PCW    = 32,
   parameter int              INSTB  = 4,
   parameter logic [PCW-1:0]  RST_PC = '0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           take_i,
   input  logic           miss_i,
   input  logic [PCW-1:0] miss_pc_i,
   input  logic           wake_i,
   output logic           rdy_o,
   output logic [PCW-1:0] pc_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdy_o <= 1'b1;
         pc_o  <= RST_PC;
      end else begin
         // a miss outranks a wake in the same cycle
         if (miss_i)      rdy_o <= 1'b0;
         else if (wake_i) rdy_o <= 1'b1;

         if (miss_i)      pc_o <= miss_pc_i;
         else if (take_i) pc_o <= pc_o + PCW'(INSTB);
      end
   end
endmodule

// File: rtl/mtsch_fetch_sched.sv
module mtsch_fetch_sched #(
   parameter int             N          = 4,
   parameter int             PCW        = 32,
   parameter int             INSTB      = 4,
   parameter logic [PCW-1:0] BOOT_PC    = '0,
   parameter logic [PCW-1:0] BOOT_STEP  = PCW'(32'h0000_1000),
   parameter int             PICK_STYLE = 0,
   localparam int            TW         = (N > 1) ? $clog2(N) : 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           imiss_vld_i,
   input  logic [TW-1:0]  imiss_tid_i,
   input  logic [PCW-1:0] imiss_pc_i,
   input  logic           dmiss_vld_i,
   input  logic [TW-1:0]  dmiss_tid_i,
   input  logic [PCW-1:0] dmiss_pc_i,
   input  logic [N-1:0]   wake_i,
   output logic           fetch_vld_o,
   output logic [TW-1:0]  fetch_tid_o,
   output logic [PCW-1:0] fetch_pc_o,
   output logic [N-1:0]   squash_o
);
   // elaboration-time parameter checks
   generate
      if (N < 2)                     begin : g_bad_n     $error("N must be at least 2"); end
      if (INSTB < 1)                 begin : g_bad_instb $error("INSTB must be positive"); end
      if (PCW < 2)                   begin : g_bad_pcw   $error("PCW too small"); end
      if (PICK_STYLE < 0 || PICK_STYLE > 1)
                                     begin : g_bad_style $error("unknown PICK_STYLE"); end
   endgenerate

   logic [N-1:0]   ihit, dhit, rdy_w, elig;
   logic [PCW-1:0] pc_w [N];
   logic [TW-1:0]  ptr_q;
   logic           pick_any;
   logic [TW-1:0]  pick_idx;

   genvar t;
   generate
      for (t = 0; t < N; t++) begin : g_thr
         assign ihit[t] = imiss_vld_i && (imiss_tid_i == TW'(t));
         assign dhit[t] = dmiss_vld_i && (dmiss_tid_i == TW'(t));

         mtsch_thr_ctx #(
            .PCW   (PCW),
            .INSTB (INSTB),
            .RST_PC(BOOT_PC + PCW'(t) * BOOT_STEP)
         ) u_ctx (
            .clk      (clk),
            .rst_n    (rst_n),
            .take_i   (pick_any && (pick_idx == TW'(t))),
            .miss_i   (ihit[t] | dhit[t]),
            .miss_pc_i(dhit[t] ? dmiss_pc_i : imiss_pc_i),
            .wake_i   (wake_i[t]),
            .rdy_o    (rdy_w[t]),
            .pc_o     (pc_w[t])
         );
      end
   endgenerate

   // a thread reported missing this cycle is dropped at once
   assign elig     = rdy_w & ~(ihit | dhit);
   assign squash_o = ihit | dhit;

   mtsch_rr_pick #(.N(N), .TW(TW), .STYLE(PICK_STYLE)) u_pick (
      .req_i(elig),
      .ptr_i(ptr_q),
      .any_o(pick_any),
      .idx_o(pick_idx)
   );

   assign fetch_vld_o = pick_any;
   assign fetch_tid_o = pick_any ? pick_idx : '0;
   assign fetch_pc_o  = pick_any ? pc_w[pick_idx] : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (pick_any) begin
         ptr_q <= (pick_idx == TW'(N - 1)) ? '0 : pick_idx + TW'(1);
      end
   end
endmodule

// File: rtl/mtsch_fetch_sched_chk.sv
module mtsch_fetch_sched_chk #(
   parameter int N  = 4,
   parameter int TW = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          imiss_vld_i,
   input logic [TW-1:0] imiss_tid_i,
   input logic          dmiss_vld_i,
   input logic [TW-1:0] dmiss_tid_i,
   input logic [N-1:0]  wake_i,
   input logic [N-1:0]  rdy,
   input logic [TW-1:0] ptr,
   input logic          fetch_vld_o,
   input logic [TW-1:0] fetch_tid_o,
   input logic [N-1:0]  squash_o
);
   logic [N-1:0] hit_c;
   logic [N-1:0] ok_c;

   a_r6_grant_ready: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_vld_o |-> rdy[fetch_tid_o]);

   a_r4_imiss_excluded: assert property (@(posedge clk) disable iff (!rst_n)
      (imiss_vld_i && fetch_vld_o) |-> (fetch_tid_o != imiss_tid_i));

   a_r5_dmiss_excluded: assert property (@(posedge clk) disable iff (!rst_n)
      (dmiss_vld_i && fetch_vld_o) |-> (fetch_tid_o != dmiss_tid_i));

   a_r5_squash_count: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(squash_o) <= (int'(imiss_vld_i) + int'(dmiss_vld_i)));

   a_r2_no_bubble: assert property (@(posedge clk) disable iff (!rst_n)
      (|ok_c) |-> fetch_vld_o);

   a_r10_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !fetch_vld_o |=> $stable(ptr));

   genvar t;
   generate
      for (t = 0; t < N; t++) begin : g_t
         logic [TW:0] wait_q;
         assign hit_c[t] = (imiss_vld_i && imiss_tid_i == TW'(t)) ||
                           (dmiss_vld_i && dmiss_tid_i == TW'(t));
         assign ok_c[t]  = rdy[t] && !hit_c[t];

         always_ff @(posedge clk) begin
            if (!rst_n) wait_q <= '0;
            else if (ok_c[t] && !(fetch_vld_o && fetch_tid_o == TW'(t)))
               wait_q <= wait_q + 1'b1;
            else
               wait_q <= '0;
         end

         a_r8_miss_wins: assert property (@(posedge clk) disable iff (!rst_n)
            hit_c[t] |=> !rdy[t]);

         a_r7_wake_sets: assert property (@(posedge clk) disable iff (!rst_n)
            (wake_i[t] && !hit_c[t]) |=> rdy[t]);

         a_r11_wait_bound: assert property (@(posedge clk) disable iff (!rst_n)
            int'(wait_q) < N);
      end
   endgenerate
endmodule

bind mtsch_fetch_sched mtsch_fetch_sched_chk #(.N(N), .TW(TW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .imiss_vld_i(imiss_vld_i),
   .imiss_tid_i(imiss_tid_i),
   .dmiss_vld_i(dmiss_vld_i),
   .dmiss_tid_i(dmiss_tid_i),
   .wake_i     (wake_i),
   .rdy        (rdy_w),
   .ptr        (ptr_q),
   .fetch_vld_o(fetch_vld_o),
   .fetch_tid_o(fetch_tid_o),
   .squash_o   (squash_o)
);

// File: tb/mtsch_fetch_sched_test.sv
module mtsch_fetch_sched_test;
   localparam int CLK_P = 10;
   localparam int N     = 4;
   localparam int TW    = 2;
   localparam int PCW   = 16;
   localparam int INSTB = 4;
   localparam logic [PCW-1:0] BOOT = 16'h0100;
   localparam logic [PCW-1:0] STEP = 16'h1000;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           imiss_vld_i = 1'b0, dmiss_vld_i = 1'b0;
   logic [TW-1:0]  imiss_tid_i = '0, dmiss_tid_i = '0;
   logic [PCW-1:0] imiss_pc_i = '0, dmiss_pc_i = '0;
   logic [N-1:0]   wake_i = '0;
   logic           fetch_vld_o;
   logic [TW-1:0]  fetch_tid_o;
   logic [PCW-1:0] fetch_pc_o;
   logic [N-1:0]   squash_o;

   int checks = 0;
   int errors = 0;

   // bench-side expectation state
   bit             m_rdy [N];
   logic [PCW-1:0] m_pc  [N];
   int             m_ptr;
   int             m_wait [N];

   always #(CLK_P/2) clk = ~clk;

   mtsch_fetch_sched #(
      .N(N), .PCW(PCW), .INSTB(INSTB), .BOOT_PC(BOOT), .BOOT_STEP(STEP), .PICK_STYLE(0)
   ) uut (
      .clk(clk), .rst_n(rst_n),
      .imiss_vld_i(imiss_vld_i), .imiss_tid_i(imiss_tid_i), .imiss_pc_i(imiss_pc_i),
      .dmiss_vld_i(dmiss_vld_i), .dmiss_tid_i(dmiss_tid_i), .dmiss_pc_i(dmiss_pc_i),
      .wake_i(wake_i),
      .fetch_vld_o(fetch_vld_o), .fetch_tid_o(fetch_tid_o), .fetch_pc_o(fetch_pc_o),
      .squash_o(squash_o)
   );

   task automatic chk(input string lbl, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", lbl, act, exp);
      end
   endtask

   // one cycle: drive after the falling edge, check just before the rising edge
   task automatic step(input string lbl,
                       input bit iv, input int it, input logic [PCW-1:0] ip,
                       input bit dv, input int dt, input logic [PCW-1:0] dp,
                       input logic [N-1:0] wk);
      bit  hit [N];
      bit  any;
      int  g;
      imiss_vld_i = iv; imiss_tid_i = TW'(it); imiss_pc_i = ip;
      dmiss_vld_i = dv; dmiss_tid_i = TW'(dt); dmiss_pc_i = dp;
      wake_i = wk;
      #(CLK_P/2 - 1);
      for (int t = 0; t < N; t++) hit[t] = (iv && it == t) || (dv && dt == t);
      any = 1'b0; g = 0;
      for (int o = 0; o < N; o++) begin
         int k;
         k = (m_ptr + o) % N;
         if (!any && m_rdy[k] && !hit[k]) begin any = 1'b1; g = k; end
      end
      chk({lbl, " vld"}, 32'(fetch_vld_o), 32'(any));
      chk({lbl, " tid"}, 32'(fetch_tid_o), any ? 32'(g) : 32'd0);
      chk({lbl, "/R3 pc"}, 32'(fetch_pc_o), any ? 32'(m_pc[g]) : 32'd0);
      for (int t = 0; t < N; t++)
         chk("R5 squash", 32'(squash_o[t]), 32'(hit[t]));
      if (fetch_vld_o)
         chk("R6 granted thread ready", 32'(m_rdy[fetch_tid_o]), 32'd1);
      // update expectation for the coming edge
      for (int t = 0; t < N; t++) begin
         if (m_rdy[t] && !hit[t] && !(any && g == t)) m_wait[t]++;
         else m_wait[t] = 0;
         if (m_wait[t] > 0) chk("R11 wait bound", 32'(m_wait[t] <= N - 1), 32'd1);
         if (hit[t]) begin
            m_rdy[t] = 1'b0;
            m_pc[t]  = (dv && dt == t) ? dp : ip;
         end else begin
            if (wk[t]) m_rdy[t] = 1'b1;
            if (any && g == t) m_pc[t] = m_pc[t] + PCW'(INSTB);
         end
      end
      if (any) m_ptr = (g + 1) % N;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle(input string lbl);
      step(lbl, 0, 0, '0, 0, 0, '0, '0);
   endtask

   initial begin
      #(CLK_P * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] r;
      for (int t = 0; t < N; t++) begin
         m_rdy[t] = 1'b1;
         m_pc[t]  = BOOT + PCW'(t) * STEP;
         m_wait[t] = 0;
      end
      m_ptr = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state, thread 0 first at its boot PC
      idle("R1");
      // R4: fetch miss on the thread the pointer now favours
      step("R4", 1, 1, 16'h1104, 0, 0, '0, '0);
      // R9: both miss kinds on thread 3 in one cycle
      step("R9", 1, 3, 16'h3AA0, 1, 3, 16'h3BB0, '0);
      // R8: miss and wake together on thread 0
      step("R8", 1, 0, 16'h0200, 0, 0, '0, 4'b0001);
      idle("R8");
      // R7: wake threads 1 and 3, they resume at their saved PCs
      step("R7", 0, 0, '0, 0, 0, '0, 4'b1010);
      repeat (4) idle("R7");
      // R10: take every thread out, then observe the idle slots
      step("R10", 1, 1, 16'h1300, 1, 3, 16'h3300, '0);
      step("R10", 0, 0, '0, 1, 2, 16'h2300, '0);
      idle("R10");
      idle("R10");
      step("R10", 0, 0, '0, 0, 0, '0, 4'b0100);
      idle("R10");
      step("R7", 0, 0, '0, 0, 0, '0, 4'b1011);
      repeat (3) idle("R7");

      // sweep with a deterministic pseudo-random source
      r = 32'h1234_5678;
      for (int c = 0; c < 6000; c++) begin
         bit iv, dv;
         int it, dt;
         logic [PCW-1:0] ip, dp;
         logic [N-1:0] wk;
         r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
         iv = (r[2:0] == 3'd0);
         it = int'(r[4:3]);
         dv = (r[7:5] == 3'd0);
         dt = int'(r[9:8]);
         ip = {r[31:20], 4'h0};
         dp = {r[19:10], 6'h04};
         wk = r[13:10] & r[17:14];
         step("R2", iv, it, ip, dv, dt, dp, wk);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule